// File: doc/BRIEF.md
# Serial Interrupt Frame Host

This block is the host end of a single shared interrupt wire. The wire is active low, open drain and clocked by the bus clock. The host opens each frame with a start pulse. It then walks a fixed series of 21 slots, each three clocks long. In the first clock of a slot, a peripheral that wants service pulls the wire low. The host samples the wire in that clock and turns the result into one level request per slot. The requests cover the legacy ISA lines, the four PCI lines and two control signals. Wherever the host drives the wire low, it drives it high for one clock and then lets go, so the pull-up never has to recover the wire on its own.

A frame ends with a stop pulse whose width picks the next mode. In continuous mode the host restarts after a short fixed idle gap. In quiet mode it waits until a peripheral pulls the wire low for one clock. When legacy disk mode is on, two of the request bits are taken from dedicated inputs and the serial slots for them are ignored.

The request vector is a set of plain levels, updated slot by slot. It has no valid/ready handshake and no back-pressure, because a level request is never consumed. The pad side is a drive-enable, a drive value and the resolved wire input.

Top module: `sirq_host`

## Requirements
- R1: During reset `irq_req_o` is all zeros and the wire is released (`line_oe_o`=0). After reset is released, the wire stays released for one more clock, and the first start pulse is driven from the second clock edge on.
- R2: A start pulse is 4 clocks driven low, then 1 clock driven high, then 1 clock released. The Sample clock of slot 0 follows at once.
- R3: Every stretch in which the host drives the wire low ends with exactly one clock driven high, followed by release.
- R4: Each slot is Sample, Recovery, Turnaround (one clock each), and the host never drives in a slot. Bit i of `irq_req_o` reflects slot i. Bits 0–1 are IRQ0–1 and bits 2–14 are IRQ3–15 (IRQ14 is bit 13, IRQ15 is bit 14). Bits 15–18 are PCI lines A–D, bit 19 is the system-management request and bit 20 is the channel-check request.
- R5: There are exactly 21 slots. The stop pulse starts on the clock right after the Turnaround clock of slot 20, 63 clocks after slot 0 starts.
- R6: A request bit is set when the wire reads low in its Sample clock and cleared when it reads high there. It holds its value at all other times.
- R7: The stop pulse is driven low for 2 clocks when `quiet_mode_i`=0 and for 3 clocks when it is 1. The mode is captured at the edge that ends the Turnaround clock of slot 20.
- R8: In continuous mode, the stop's high clock is followed by one released clock and then an idle gap of 2 released clocks, after which the next start pulse begins.
- R9: In quiet mode the host stays released after a frame until the wire reads low for one clock. The start pulse then begins on the next clock.
- R10: While `legacy_disk_i`=1, bits 13 and 14 equal `disk_irq_i[0]` and `disk_irq_i[1]` combinationally, and the wire's value in slots 13 and 14 has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Resolved level of the shared wire |
| line_oe_o | output | 1 | Host drives the wire when 1 |
| line_o | output | 1 | Value driven when `line_oe_o`=1 |
| quiet_mode_i | input | 1 | Selects quiet (1) or continuous (0) mode for the next stop pulse |
| legacy_disk_i | input | 1 | Takes IRQ14/IRQ15 from dedicated inputs |
| disk_irq_i | input | 2 | Dedicated IRQ14 (bit 0) and IRQ15 (bit 1) |
| irq_req_o | output | 21 | Decoded level requests, one per slot |

## Verification
Two situations are hard to reach from the ports. The first is the quiet-mode wake, which only exists after a frame that ended with a three-clock stop. The bench ends such a frame, watches the wire stay released for a stretch, and then pulls it low for exactly one clock to confirm that the start pulse follows on the next clock. The second is legacy masking, which matters only while peripherals are active in the two disk slots. The bench runs frames with every slot asserted while legacy mode is on, then flips the dedicated inputs between frames to show that only they reach those bits.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Frame-level sequencing states
  typedef enum logic [3:0] {
    FS_GAP      = 4'd0,
    FS_WAIT     = 4'd1,
    FS_START_LO = 4'd2,
    FS_START_HI = 4'd3,
    FS_START_TA = 4'd4,
    FS_SLOT     = 4'd5,
    FS_STOP_LO  = 4'd6,
    FS_STOP_HI  = 4'd7,
    FS_STOP_TA  = 4'd8
  } frame_st_e;

  // Phase inside a three-clock slot
  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } slot_ph_e;

  // Host pad drive
  typedef struct packed {
    logic oe;
    logic val;
  } pad_drv_t;

endpackage

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 21,
  parameter int START_LO   = 4,
  parameter int STOP_CONT  = 2,
  parameter int STOP_QUIET = 3,
  parameter int GAP_CLKS   = 2,
  parameter int IDXW       = $clog2(NUM_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_i,
  input  logic            quiet_i,
  output pad_drv_t        drv,
  output logic            sample_en,
  output logic [IDXW-1:0] slot_idx
);

  localparam int CNTW = $clog2(START_LO + STOP_QUIET + GAP_CLKS + 1);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_SLOTS - 1);

  frame_st_e       st_q, st_d;
  slot_ph_e        ph_q, ph_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            quiet_q, quiet_d;
  logic [CNTW-1:0] stop_last;

  assign stop_last = quiet_q ? CNTW'(STOP_QUIET - 1) : CNTW'(STOP_CONT - 1);

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    quiet_d = quiet_q;
    unique case (st_q)
      FS_GAP: begin
        if (cnt_q == CNTW'(GAP_CLKS - 1)) begin
          st_d  = FS_START_LO;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      FS_WAIT: begin
        if (!line_i) begin
          st_d  = FS_START_LO;
          cnt_d = '0;
        end
      end
      FS_START_LO: begin
        if (cnt_q == CNTW'(START_LO - 1)) begin
          st_d  = FS_START_HI;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      FS_START_HI: st_d = FS_START_TA;
      FS_START_TA: begin
        st_d  = FS_SLOT;
        ph_d  = PH_SAMPLE;
        idx_d = '0;
      end
      FS_SLOT: begin
        unique case (ph_q)
          PH_SAMPLE:  ph_d = PH_RECOVER;
          PH_RECOVER: ph_d = PH_TURN;
          PH_TURN: begin
            if (idx_q == LAST_IDX) begin
              st_d    = FS_STOP_LO;
              cnt_d   = '0;
              quiet_d = quiet_i;
            end else begin
              idx_d = idx_q + IDXW'(1);
              ph_d  = PH_SAMPLE;
            end
          end
          default: ph_d = PH_SAMPLE;
        endcase
      end
      FS_STOP_LO: begin
        if (cnt_q == stop_last) begin
          st_d  = FS_STOP_HI;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      FS_STOP_HI: st_d = FS_STOP_TA;
      FS_STOP_TA: begin
        st_d  = quiet_q ? FS_WAIT : FS_GAP;
        cnt_d = '0;
      end
      default: begin
        st_d  = FS_GAP;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= FS_GAP;
      ph_q    <= PH_SAMPLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      quiet_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      quiet_q <= quiet_d;
    end
  end

  always_comb begin
    drv = '{oe: 1'b0, val: 1'b1};
    if (st_q == FS_START_LO || st_q == FS_STOP_LO) begin
      drv = '{oe: 1'b1, val: 1'b0};
    end else if (st_q == FS_START_HI || st_q == FS_STOP_HI) begin
      drv = '{oe: 1'b1, val: 1'b1};
    end
  end

  assign sample_en = (st_q == FS_SLOT) && (ph_q == PH_SAMPLE);
  assign slot_idx  = idx_q;

  AST_HIGH_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv.oe) |-> $past(drv.val)); // R3

  AST_LOW_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drv.oe && !drv.val) && !(drv.oe && !drv.val)) |-> (drv.oe && drv.val)); // R3

  AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_q == FS_SLOT && ph_q == PH_TURN && idx_q == LAST_IDX) |-> (drv.oe && !drv.val)); // R5

  AST_QUIET_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_q == FS_WAIT && !line_i) |-> (drv.oe && !drv.val)); // R9

  AST_SILENT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_SLOT) |-> !drv.oe); // R4

endmodule

// File: rtl/sirq_slot_capture.sv
module sirq_slot_capture #(
  parameter int NUM_SLOTS = 21,
  parameter int DISK_LO   = 13,
  parameter int DISK_HI   = 14,
  parameter int IDXW      = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic [IDXW-1:0]      slot_idx,
  input  logic                 line_i,
  input  logic                 legacy_i,
  output logic [NUM_SLOTS-1:0] req_q
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = sample_en && (slot_idx == IDXW'(g));
    if (g == DISK_LO || g == DISK_HI) begin : g_disk
      // Serial value is discarded while the dedicated inputs own this slot
      always_ff @(posedge clk) begin
        if (!rst_n)   req_q[g] <= 1'b0;
        else if (hit) req_q[g] <= legacy_i ? 1'b0 : !line_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)   req_q[g] <= 1'b0;
        else if (hit) req_q[g] <= !line_i;
      end
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(req_q)); // R6

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (int'(slot_idx) < NUM_SLOTS)); // R5

  AST_DISK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && legacy_i && slot_idx == IDXW'(DISK_HI)) |=> !req_q[DISK_HI]); // R10

endmodule

// File: rtl/sirq_legacy_merge.sv
module sirq_legacy_merge #(
  parameter int NUM_SLOTS = 21,
  parameter int DISK_LO   = 13,
  parameter int DISK_HI   = 14
) (
  input  logic [NUM_SLOTS-1:0] serial_req,
  input  logic                 legacy_i,
  input  logic [1:0]           disk_irq_i,
  output logic [NUM_SLOTS-1:0] req_o
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bit
    if (g == DISK_LO) begin : g_lo
      assign req_o[g] = legacy_i ? disk_irq_i[0] : serial_req[g];
    end else if (g == DISK_HI) begin : g_hi
      assign req_o[g] = legacy_i ? disk_irq_i[1] : serial_req[g];
    end else begin : g_pass
      assign req_o[g] = serial_req[g];
    end
  end

endmodule

// File: rtl/sirq_host.sv
module sirq_host
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 21,
  parameter int DISK_LO    = 13,
  parameter int DISK_HI    = 14,
  parameter int START_LO   = 4,
  parameter int STOP_CONT  = 2,
  parameter int STOP_QUIET = 3,
  parameter int GAP_CLKS   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_i,
  output logic                 line_oe_o,
  output logic                 line_o,
  input  logic                 quiet_mode_i,
  input  logic                 legacy_disk_i,
  input  logic [1:0]           disk_irq_i,
  output logic [NUM_SLOTS-1:0] irq_req_o
);

  localparam int IDXW = $clog2(NUM_SLOTS);

  pad_drv_t              drv;
  logic                  sample_en;
  logic [IDXW-1:0]       slot_idx;
  logic [NUM_SLOTS-1:0]  serial_req;

  sirq_frame_seq #(
    .NUM_SLOTS (NUM_SLOTS),
    .START_LO  (START_LO),
    .STOP_CONT (STOP_CONT),
    .STOP_QUIET(STOP_QUIET),
    .GAP_CLKS  (GAP_CLKS),
    .IDXW      (IDXW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line_i),
    .quiet_i  (quiet_mode_i),
    .drv      (drv),
    .sample_en(sample_en),
    .slot_idx (slot_idx)
  );

  sirq_slot_capture #(
    .NUM_SLOTS(NUM_SLOTS),
    .DISK_LO  (DISK_LO),
    .DISK_HI  (DISK_HI),
    .IDXW     (IDXW)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(sample_en),
    .slot_idx (slot_idx),
    .line_i   (line_i),
    .legacy_i (legacy_disk_i),
    .req_q    (serial_req)
  );

  sirq_legacy_merge #(
    .NUM_SLOTS(NUM_SLOTS),
    .DISK_LO  (DISK_LO),
    .DISK_HI  (DISK_HI)
  ) u_merge (
    .serial_req(serial_req),
    .legacy_i  (legacy_disk_i),
    .disk_irq_i(disk_irq_i),
    .req_o     (irq_req_o)
  );

  assign line_oe_o = drv.oe;
  assign line_o    = drv.val;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (irq_req_o == '0 || legacy_disk_i)); // R1

endmodule

// File: tb/tb_sirq_host.sv
module tb_sirq_host;
  localparam int NS  = 21;
  localparam int DLO = 13;
  localparam int DHI = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic periph_low = 1'b0;
  logic quiet = 1'b0;
  logic legacy = 1'b0;
  logic [1:0] disk = 2'b00;
  logic oe, dv, line;
  logic [NS-1:0] irq;

  // Wired-AND pad with pull-up
  assign line = !((oe && !dv) || periph_low);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sirq_host dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line),
    .line_oe_o    (oe),
    .line_o       (dv),
    .quiet_mode_i (quiet),
    .legacy_disk_i(legacy),
    .disk_irq_i   (disk),
    .irq_req_o    (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] expect_vec(input logic [NS-1:0] pat);
    logic [NS-1:0] r;
    r = pat;
    if (legacy) begin
      r[DLO] = disk[0];
      r[DHI] = disk[1];
    end
    return r;
  endfunction

  // Runs one frame from its start pulse, driving pat into the slots
  task automatic do_frame(input logic [NS-1:0] pat);
    int n;
    while (!(oe && !dv)) @(negedge clk);
    n = 0;
    while (oe && !dv) begin n++; @(negedge clk); end
    check("R2 start low length", n, 4);
    check("R2 start high clock", {oe, dv}, 2'b11);
    @(negedge clk);
    check("R3 release after start high", oe, 0);
    @(negedge clk);
    for (int i = 0; i < NS; i++) begin
      periph_low = pat[i];
      @(negedge clk);
      periph_low = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    check("R5 stop begins after slot 20", {oe, dv}, 2'b10);
    check("R4 R6 decoded vector", irq, expect_vec(pat));
    n = 0;
    while (oe && !dv) begin n++; @(negedge clk); end
    check("R7 stop low length", n, quiet ? 3 : 2);
    check("R3 stop high clock", {oe, dv}, 2'b11);
    if (!quiet) begin
      @(negedge clk);
      n = 0;
      while (!oe) begin n++; @(negedge clk); end
      check("R8 released clocks before restart", n, 3);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] held;
    bit idle_ok;
    repeat (3) @(negedge clk);
    check("R1 reset vector", irq, 0);
    check("R1 reset line released", oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 released one clock after reset", oe, 0);
    @(negedge clk);
    check("R1 start on second edge", {oe, dv}, 2'b10);

    do_frame('0);
    do_frame('1);
    do_frame('0);                      // R6 clear on high
    for (int i = 0; i < NS; i++) do_frame(NS'(1) << i);      // R4 walking one
    for (int i = 0; i < NS; i++) do_frame(~(NS'(1) << i));   // R4 walking zero
    for (int k = 1; k <= 6; k++) do_frame(NS'((k * 32'h9E3779B1) >> 7));

    // R10 legacy disk mode
    legacy = 1'b1;
    disk = 2'b10;
    do_frame('1);
    disk = 2'b01;
    #1;
    check("R10 dedicated inputs pass through", irq[DHI:DLO], 2'b01);
    disk = 2'b11;
    do_frame('0);
    legacy = 1'b0;
    do_frame('1);

    // R9 quiet mode
    quiet = 1'b1;
    do_frame(NS'(21'h0A5A5A));
    held = irq;
    idle_ok = 1'b1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (oe) idle_ok = 1'b0;
    end
    check("R9 idle while quiet", idle_ok, 1);
    check("R6 requests held while idle", irq, held);
    periph_low = 1'b1;
    @(negedge clk);
    periph_low = 1'b0;
    check("R9 start follows wake pulse", {oe, dv}, 2'b10);
    quiet = 1'b0;
    do_frame(NS'(21'h15A5A5));
    do_frame('0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule